// File: doc/BRIEF.md
# Transceiver Basic Control and Status Registers

This block holds the two basic management registers of a 10/100 Ethernet transceiver: a control word at address 0 and a status word at address 1. They are reached through a plain synchronous register port with a 5-bit address, a write strobe, a read strobe and 16-bit data. Read data is combinational from the current address. Every other address reads as zero and ignores writes.

The block also drives the control lines that the rest of the transceiver uses. These are loopback, speed, duplex, auto-negotiation enable, an auto-negotiation restart pulse, power-down, isolate, collision test, transmit disable and a one-cycle soft reset request. Strap inputs supply the default values of some fields, at power-on reset and at soft reset. While auto-negotiation is enabled, the speed and duplex lines follow the negotiation result inputs and ignore the written bits. An active-low pin can force power-down. The status word reports fixed capability flags, a live negotiation-complete bit and a link bit that latches low.

Top module: `phy_basic_regs`

## Requirements
- R1: After reset, address 0 reads with bit 13 = strap_speed, bit 12 = strap_aneg, bit 10 = strap_iso and bit 8 = strap_duplex, and all other bits 0. sw_reset_pulse and aneg_restart are low.
- R2: A write to address 0 stores bits 14, 13, 12, 11, 10, 8, 7 and 0, and a read of address 0 returns exactly those stored bits. Bits 6 to 1 always read 0.
- R3: loopback follows bit 14, isolate bit 10, col_test bit 7 and tx_disable bit 0 of the stored control word.
- R4: When bit 12 is 1, speed_100 equals neg_speed and full_duplex equals neg_duplex. When bit 12 is 0, they follow bits 13 and 8. The stored bits 13 and 8 still read back as written.
- R5: power_down is high when bit 11 is 1 or when pd_pin_n is low. The pin does not change the value read from bit 11.
- R6: A write to address 0 with bit 15 = 1 restores the R1 defaults and ignores the rest of the write data. sw_reset_pulse is then high for exactly the one cycle after the write edge. Bit 15 always reads 0.
- R7: A write to address 0 with bit 9 = 1 and bit 15 = 0 raises aneg_restart for exactly the one cycle after the write edge, and bit 9 reads 0. When bit 15 is also 1, no restart pulse is issued.
- R8: Address 1 reads bits 15..11 as 0,1,1,1,1, with bit 3 = 1 and bit 0 = 1. Bits 14..6, 4 and 1 other than the capability bits read 0. Writes to address 1 change nothing.
- R9: Bit 5 of address 1 reflects aneg_done in the same cycle.
- R10: Bit 2 of address 1 is a latch-low link flag. It resets to 0 and is cleared in any cycle in which link_up is low. A read strobe of address 1 returns the held value and then reloads the flag from link_up.
- R11: Addresses other than 0 and 1 read 0, and writes to them leave the control outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_speed | input | 1 | Default for the speed bit |
| strap_aneg | input | 1 | Default for the auto-negotiation enable bit |
| strap_iso | input | 1 | Default for the isolate bit |
| strap_duplex | input | 1 | Default for the duplex bit |
| pd_pin_n | input | 1 | Active-low hardware power-down request |
| neg_speed | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| neg_duplex | input | 1 | Negotiated duplex, 1 = full |
| link_up | input | 1 | Live link indication |
| aneg_done | input | 1 | Auto-negotiation complete |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, used for the latch reload |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| sw_reset_pulse | output | 1 | One-cycle soft reset request |
| loopback | output | 1 | Loopback enable |
| speed_100 | output | 1 | Effective speed, 1 = 100 Mb/s |
| full_duplex | output | 1 | Effective duplex, 1 = full |
| aneg_enable | output | 1 | Auto-negotiation enable |
| aneg_restart | output | 1 | One-cycle auto-negotiation restart |
| power_down | output | 1 | Power-down request |
| isolate | output | 1 | Isolate request |
| col_test | output | 1 | Collision test enable |
| tx_disable | output | 1 | Transmitter disable |

## Verification
The control word is written with a series of patterns:
- all zero;
- speed and duplex with negotiation off, then the same bits with negotiation on and opposing negotiation results, which separates the override from the stored value;
- single-field words for loopback, collision test, transmit disable, power-down and isolate;
- only the reserved bits, to show that they are dropped;
- the pin-driven power-down with the register bit clear.

The self-clearing commands are written alone and combined with other bits, which shows the reset taking priority and the pulse width. The status word is read across link drops and recoveries, which separates a live link bit from a latch-low one that needs a read to re-arm.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int CB_RESET   = 15;
   localparam int CB_LOOP    = 14;
   localparam int CB_SPEED   = 13;
   localparam int CB_ANEN    = 12;
   localparam int CB_PDOWN   = 11;
   localparam int CB_ISO     = 10;
   localparam int CB_RESTART = 9;
   localparam int CB_DUPLEX  = 8;
   localparam int CB_COLTST  = 7;
   localparam int CB_TXDIS   = 0;

   localparam int SB_CAP_LSB = 11;
   localparam int SB_CAP_W   = 5;
   localparam int SB_ANDONE  = 5;
   localparam int SB_ANABLE  = 3;
   localparam int SB_LINK    = 2;
   localparam int SB_EXTCAP  = 0;

   typedef struct packed {
      logic loopback;
      logic speed;
      logic aneg_en;
      logic pdown;
      logic isolate;
      logic duplex;
      logic col_test;
      logic tx_dis;
   } ctrl_t;

   function automatic logic [15:0] ctrl_to_word(ctrl_t c);
      logic [15:0] w;
      w = '0;
      w[CB_LOOP]   = c.loopback;
      w[CB_SPEED]  = c.speed;
      w[CB_ANEN]   = c.aneg_en;
      w[CB_PDOWN]  = c.pdown;
      w[CB_ISO]    = c.isolate;
      w[CB_DUPLEX] = c.duplex;
      w[CB_COLTST] = c.col_test;
      w[CB_TXDIS]  = c.tx_dis;
      return w;
   endfunction

   function automatic ctrl_t word_to_ctrl(logic [15:0] w);
      ctrl_t c;
      c.loopback = w[CB_LOOP];
      c.speed    = w[CB_SPEED];
      c.aneg_en  = w[CB_ANEN];
      c.pdown    = w[CB_PDOWN];
      c.isolate  = w[CB_ISO];
      c.duplex   = w[CB_DUPLEX];
      c.col_test = w[CB_COLTST];
      c.tx_dis   = w[CB_TXDIS];
      return c;
   endfunction

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              strap_speed,
   input  logic              strap_aneg,
   input  logic              strap_iso,
   input  logic              strap_duplex,
   output ctrl_t             ctrl_q,
   output logic              rst_pulse,
   output logic              restart_pulse
);

   ctrl_t dflt;
   logic  wire_unused_bits;

   always_comb begin
      dflt          = '0;
      dflt.speed    = strap_speed;
      dflt.aneg_en  = strap_aneg;
      dflt.isolate  = strap_iso;
      dflt.duplex   = strap_duplex;
   end

   assign wire_unused_bits = &{1'b0, wdata[6:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q        <= dflt;
         rst_pulse     <= 1'b0;
         restart_pulse <= 1'b0;
      end else begin
         rst_pulse     <= 1'b0;
         restart_pulse <= 1'b0;
         if (wr_en) begin
            if (wdata[CB_RESET]) begin
               ctrl_q    <= dflt;
               rst_pulse <= 1'b1;
            end else begin
               ctrl_q        <= word_to_ctrl(wdata[15:0]);
               restart_pulse <= wdata[CB_RESTART];
            end
         end
      end
   end

endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
   import phy_mgmt_pkg::*;
#(
   parameter int                DATA_W     = 16,
   parameter logic [SB_CAP_W-1:0] CAP_FLAGS = 5'b01111,
   parameter bit                LATCH_LINK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic              link_up,
   input  logic              aneg_done,
   output logic [DATA_W-1:0] stat_word
);

   logic link_bit;

   generate
      if (LATCH_LINK) begin : g_latch_low
         logic link_hold;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               link_hold <= 1'b0;
            else if (rd_strobe)
               link_hold <= link_up;
            else
               link_hold <= link_hold & link_up;
         end
         assign link_bit = link_hold;
      end else begin : g_live
         logic wire_unused_live;
         assign wire_unused_live = &{1'b0, clk, rst_n, rd_strobe};
         assign link_bit = link_up;
      end
   endgenerate

   always_comb begin
      stat_word = '0;
      stat_word[SB_CAP_LSB +: SB_CAP_W] = CAP_FLAGS;
      stat_word[SB_ANDONE] = aneg_done;
      stat_word[SB_ANABLE] = 1'b1;
      stat_word[SB_LINK]   = link_bit;
      stat_word[SB_EXTCAP] = 1'b1;
   end

endmodule

// File: rtl/phy_mode_resolve.sv
module phy_mode_resolve
   import phy_mgmt_pkg::*;
(
   input  ctrl_t ctrl,
   input  logic  neg_speed,
   input  logic  neg_duplex,
   input  logic  pd_pin_n,
   output logic  speed_100,
   output logic  full_duplex,
   output logic  power_down
);

   always_comb begin
      if (ctrl.aneg_en) begin
         speed_100   = neg_speed;
         full_duplex = neg_duplex;
      end else begin
         speed_100   = ctrl.speed;
         full_duplex = ctrl.duplex;
      end
      power_down = ctrl.pdown | ~pd_pin_n;
   end

endmodule

// File: rtl/phy_rd_mux.sv
module phy_rd_mux #(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] stat_word,
   output logic [DATA_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CTRL_ADDR))
         rdata = ctrl_word;
      else if (addr == ADDR_W'(STAT_ADDR))
         rdata = stat_word;
   end

endmodule

// File: rtl/phy_basic_regs.sv
module phy_basic_regs
   import phy_mgmt_pkg::*;
#(
   parameter int          ADDR_W     = 5,
   parameter int          DATA_W     = 16,
   parameter int          CTRL_ADDR  = 0,
   parameter int          STAT_ADDR  = 1,
   parameter logic [4:0]  CAP_FLAGS  = 5'b01111,
   parameter bit          LATCH_LINK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strap_speed,
   input  logic              strap_aneg,
   input  logic              strap_iso,
   input  logic              strap_duplex,
   input  logic              pd_pin_n,
   input  logic              neg_speed,
   input  logic              neg_duplex,
   input  logic              link_up,
   input  logic              aneg_done,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sw_reset_pulse,
   output logic              loopback,
   output logic              speed_100,
   output logic              full_duplex,
   output logic              aneg_enable,
   output logic              aneg_restart,
   output logic              power_down,
   output logic              isolate,
   output logic              col_test,
   output logic              tx_disable
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W != 16) begin : g_bad_data_w
         $error("phy_basic_regs: DATA_W must be 16");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("phy_basic_regs: ADDR_W out of range");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_addr_clash
         $error("phy_basic_regs: control and status addresses collide");
      end
      if (CTRL_ADDR >= ADDR_SPAN || STAT_ADDR >= ADDR_SPAN) begin : g_addr_range
         $error("phy_basic_regs: register address beyond address space");
      end
   endgenerate

   logic              ctrl_sel;
   logic              stat_sel;
   ctrl_t             ctrl_q;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] stat_word;

   assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_ADDR));
   assign stat_sel = (reg_addr == ADDR_W'(STAT_ADDR));

   phy_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (reg_wr & ctrl_sel),
      .wdata         (reg_wdata),
      .strap_speed   (strap_speed),
      .strap_aneg    (strap_aneg),
      .strap_iso     (strap_iso),
      .strap_duplex  (strap_duplex),
      .ctrl_q        (ctrl_q),
      .rst_pulse     (sw_reset_pulse),
      .restart_pulse (aneg_restart)
   );

   phy_stat_reg #(
      .DATA_W     (DATA_W),
      .CAP_FLAGS  (CAP_FLAGS),
      .LATCH_LINK (LATCH_LINK)
   ) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_strobe (reg_rd & stat_sel),
      .link_up   (link_up),
      .aneg_done (aneg_done),
      .stat_word (stat_word)
   );

   phy_mode_resolve u_mode (
      .ctrl        (ctrl_q),
      .neg_speed   (neg_speed),
      .neg_duplex  (neg_duplex),
      .pd_pin_n    (pd_pin_n),
      .speed_100   (speed_100),
      .full_duplex (full_duplex),
      .power_down  (power_down)
   );

   assign ctrl_word = DATA_W'(ctrl_to_word(ctrl_q));

   phy_rd_mux #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) u_rd (
      .addr      (reg_addr),
      .ctrl_word (ctrl_word),
      .stat_word (stat_word),
      .rdata     (reg_rdata)
   );

   assign loopback    = ctrl_q.loopback;
   assign aneg_enable = ctrl_q.aneg_en;
   assign isolate     = ctrl_q.isolate;
   assign col_test    = ctrl_q.col_test;
   assign tx_disable  = ctrl_q.tx_dis;

endmodule

// File: rtl/phy_basic_regs_chk.sv
module phy_basic_regs_chk #(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              strap_aneg,
   input logic              pd_pin_n,
   input logic              neg_speed,
   input logic              neg_duplex,
   input logic              link_up,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              sw_reset_pulse,
   input logic              loopback,
   input logic              speed_100,
   input logic              full_duplex,
   input logic              aneg_enable,
   input logic              aneg_restart,
   input logic              power_down,
   input logic              isolate,
   input logic              col_test,
   input logic              tx_disable
);

   logic ctrl_wr;
   logic other_wr;
   logic stat_rd;

   assign ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));
   assign other_wr = reg_wr && (reg_addr != ADDR_W'(CTRL_ADDR));
   assign stat_rd  = reg_rd && (reg_addr == ADDR_W'(STAT_ADDR));

   // R2
   a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(CTRL_ADDR)) |-> (reg_rdata[6:1] == 6'd0));

   // R4
   a_r4_speed_override: assert property (@(posedge clk) disable iff (!rst_n)
      aneg_enable |-> (speed_100 == neg_speed && full_duplex == neg_duplex));

   // R5
   a_r5_pd_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[15] && reg_wdata[11]) |=> power_down);

   // R5
   a_r5_pd_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (!pd_pin_n) |-> power_down);

   // R6
   a_r6_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && reg_wdata[15]) |=>
         (sw_reset_pulse && !aneg_restart && !loopback && !col_test && !tx_disable
          && aneg_enable == $past(strap_aneg)));

   // R6
   a_r6_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_reset_pulse && !(ctrl_wr && reg_wdata[15])) |=> !sw_reset_pulse);

   // R7
   a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !reg_wdata[15] && reg_wdata[9]) |=> aneg_restart);

   // R7
   a_r7_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
      (aneg_restart && !(ctrl_wr && reg_wdata[9])) |=> !aneg_restart);

   // R8
   a_r8_caps: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(STAT_ADDR)) |-> (reg_rdata[15:11] == 5'b01111));

   // R10
   a_r10_link_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_up && !stat_rd) |=>
         ((reg_addr == ADDR_W'(STAT_ADDR)) |-> !reg_rdata[2]));

   // R11
   a_r11_other_write: assert property (@(posedge clk) disable iff (!rst_n)
      other_wr |=> $stable({loopback, aneg_enable, isolate, col_test, tx_disable}));

endmodule

bind phy_basic_regs phy_basic_regs_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CTRL_ADDR (CTRL_ADDR),
   .STAT_ADDR (STAT_ADDR)
) u_chk (.*);

// File: tb/phy_basic_regs_test.sv
`timescale 1ns/100ps
module phy_basic_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_speed = 1'b1;
   logic        strap_aneg = 1'b1;
   logic        strap_iso = 1'b0;
   logic        strap_duplex = 1'b1;
   logic        pd_pin_n = 1'b1;
   logic        neg_speed = 1'b0;
   logic        neg_duplex = 1'b0;
   logic        link_up = 1'b0;
   logic        aneg_done = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        sw_reset_pulse, loopback, speed_100, full_duplex, aneg_enable;
   logic        aneg_restart, power_down, isolate, col_test, tx_disable;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   phy_basic_regs uut (.*);

   // {wdata[16], neg_speed, neg_duplex, pd_pin_n,
   //  expected {loop,speed,aneg,pd,iso,dup,col,txdis}, expected readback[16]}
   localparam int NV = 9;
   localparam logic [42:0] VECS [NV] = '{
      {16'h0000, 1'b0, 1'b0, 1'b1, 8'b00000000, 16'h0000},
      {16'h2100, 1'b0, 1'b0, 1'b1, 8'b01000100, 16'h2100},
      {16'h3100, 1'b0, 1'b0, 1'b1, 8'b00100000, 16'h3100},
      {16'h1000, 1'b1, 1'b1, 1'b1, 8'b01100100, 16'h1000},
      {16'h4081, 1'b0, 1'b0, 1'b1, 8'b10000011, 16'h4081},
      {16'h007E, 1'b0, 1'b0, 1'b1, 8'b00000000, 16'h0000},
      {16'h0800, 1'b0, 1'b0, 1'b1, 8'b00010000, 16'h0800},
      {16'h0000, 1'b0, 1'b0, 1'b0, 8'b00010000, 16'h0000},
      {16'h0400, 1'b0, 1'b0, 1'b1, 8'b00001000, 16'h0400}
   };

   function automatic logic [7:0] outs();
      return {loopback, speed_100, aneg_enable, power_down,
              isolate, full_duplex, col_test, tx_disable};
   endfunction

   task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
      #1;
   endtask

   task automatic rd(input logic [4:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [15:0] r;
      logic [15:0] st;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;

      // R1 reset state
      check("R1 sw_reset_pulse low", {15'd0, sw_reset_pulse}, 16'h0000);
      check("R1 aneg_restart low", {15'd0, aneg_restart}, 16'h0000);
      check("R1 outputs", {8'd0, outs()}, {8'd0, 8'b00100000});
      rd(5'd0, r);
      check("R1 reg0 defaults", r, 16'h3100);
      rd(5'd1, r);
      check("R8 R10 status after reset", r, 16'h7809);

      // Vector table: R2 R3 R4 R5
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         neg_speed  = VECS[i][26];
         neg_duplex = VECS[i][25];
         pd_pin_n   = VECS[i][24];
         wr(5'd0, VECS[i][42:27]);
         check($sformatf("R3 R4 R5 outputs vec %0d", i), {8'd0, outs()}, {8'd0, VECS[i][23:16]});
         rd(5'd0, r);
         check($sformatf("R2 readback vec %0d", i), r, VECS[i][15:0]);
      end

      // R11 other addresses
      rd(5'd2, r);
      check("R11 addr 2 reads zero", r, 16'h0000);
      rd(5'd31, r);
      check("R11 addr 31 reads zero", r, 16'h0000);
      wr(5'd5, 16'h4081);
      check("R11 write addr 5 ignored", {8'd0, outs()}, {8'd0, 8'b00001000});

      // R8 writes to status ignored
      wr(5'd1, 16'hFFFF);
      rd(5'd1, r);
      check("R8 status unchanged by write", r, 16'h7809);
      rd(5'd0, r);
      check("R8 reg0 unchanged by status write", r, 16'h0400);

      // R7 restart pulse
      wr(5'd0, 16'h1200);
      check("R7 restart pulse high", {15'd0, aneg_restart}, 16'h0001);
      @(negedge clk); #1;
      check("R7 restart pulse one cycle", {15'd0, aneg_restart}, 16'h0000);
      rd(5'd0, r);
      check("R7 bit 9 reads zero", r, 16'h1000);

      // R6 soft reset with restart also set
      wr(5'd0, 16'h4081);
      wr(5'd0, 16'hC281);
      check("R6 reset pulse high", {15'd0, sw_reset_pulse}, 16'h0001);
      check("R7 no restart with reset", {15'd0, aneg_restart}, 16'h0000);
      check("R6 defaults restored", {8'd0, outs()}, {8'd0, 8'b00100000});
      @(negedge clk); #1;
      check("R6 reset pulse one cycle", {15'd0, sw_reset_pulse}, 16'h0000);
      rd(5'd0, r);
      check("R6 readback defaults", r, 16'h3100);

      // R10 latch-low link, R9 live negotiation complete
      link_up = 1'b1;
      repeat (2) @(negedge clk);
      rd(5'd1, st);
      check("R10 held low until read", st, 16'h7809);
      rd(5'd1, st);
      check("R10 reloaded after read", st, 16'h780D);
      @(negedge clk);
      link_up = 1'b0;
      @(negedge clk);
      link_up = 1'b1;
      rd(5'd1, st);
      check("R10 drop latched", st, 16'h7809);
      rd(5'd1, st);
      check("R10 re-armed", st, 16'h780D);
      aneg_done = 1'b1;
      rd(5'd1, st);
      check("R9 aneg done live", st, 16'h782D);
      aneg_done = 1'b0;
      rd(5'd1, st);
      check("R9 aneg done cleared", st, 16'h780D);

      done = 1'b1;
      finish_run();
   end

endmodule